// File: doc/BRIEF.md
# SDRAM Command Decoder

This block sits right after the pins of a double-data-rate SDRAM control port. On every rising clock edge it samples chip select, the row strobe, the column strobe, write enable, clock enable, the bank select bits and address bit 10. It turns these into exactly one command strobe. It keeps the clock-enable level from the previous edge, so it can tell power-down and self-refresh entry and exit apart from normal commands. Any combination that has no defined meaning becomes a no-op.

Next to the strobe, the block reports the addressed bank and an auto-precharge flag. It also marks a command as illegal when it does not fit the current bank state. To do this it keeps a bit for each bank showing whether a row is open, a self-refresh marker, and a short counter that guards the gap after a mode register load. All outputs are registered, so results appear one cycle after the inputs are sampled. The memory array and the data path are outside this block.

Top module: `sdram_cmd_dec`

## Requirements
- R1: `cmd_o` is one-hot and registered, and changes on the edge that samples the inputs. The bit order is 0 no-op, 1 mode load, 2 extended mode load, 3 activate, 4 read, 5 write, 6 burst stop, 7 single-bank precharge, 8 all-bank precharge, 9 auto refresh, 10 self-refresh entry, 11 self-refresh exit, 12 idle power-down entry, 13 active power-down entry, 14 power-down exit. While reset is active and after it, `cmd_o` is the no-op bit, and all other outputs and all state are zero.
- R2: When clock enable is high on both the previous and the current edge and `cs_ni` is high, the result is a no-op, whatever the other inputs are.
- R3: When clock enable stays high and `cs_ni` is low, the code {ras_ni,cas_ni,we_ni} decodes as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh, 110 burst stop, 111 no-op. `bank_o` equals `ba_i` (0..3 meaning banks A..D) for activate, read, write and single-bank precharge, and is 0 for every other command.
- R4: On a precharge code, `a10_i` high gives the all-bank precharge and `bank_o` is 0, ignoring `ba_i`. On a read or write, `a10_i` high sets `auto_pre_o`. `auto_pre_o` is 0 for every other command.
- R5: Code 000 loads the mode register when `ba_i` is 0 and the extended mode register when `ba_i` is 1. Any other `ba_i` value gives a no-op.
- R6: When clock enable falls (previous high, current low), code 001 with `cs_ni` low enters self refresh. A deselect or code 111 enters power-down: idle power-down if no row is open, active power-down otherwise. Any other code gives a no-op.
- R7: When clock enable rises, a deselect or code 111 gives self-refresh exit if self refresh was entered before, and power-down exit otherwise. Other codes give a no-op. Any rise clears the self-refresh marker. When clock enable stays low, the result is a no-op.
- R8: `open_rows_o` changes only on legal commands. Activate sets the bank's bit. Single-bank precharge clears it. All-bank precharge clears every bit. A read or write with auto precharge clears the addressed bank's bit. The new value is visible together with the command strobe.
- R9: `illegal_o` is raised for mode loads, auto refresh or self-refresh entry while any row is open, for an activate to an open bank, and for a read or write to a closed bank. An illegal command leaves `open_rows_o` unchanged and does not start the mode-load guard.
- R10: After a legal mode load or extended mode load, any command other than a no-op sampled within the next MRD_CYCLES-1 edges is flagged illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; inputs sampled on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable, current level |
| a10_i | input | 1 | Address bit 10 (auto precharge / all banks) |
| ba_i | input | BANK_W | Bank select |
| cmd_o | output | CMD_N | One-hot decoded command |
| bank_o | output | BANK_W | Decoded bank index |
| auto_pre_o | output | 1 | Auto precharge requested |
| illegal_o | output | 1 | Command illegal in current state |
| open_rows_o | output | NUM_BANKS | Open-row vector per bank |

## Verification
The bench builds the block with four banks and MRD_CYCLES set to 3 instead of the default 2. This widens the guard after a mode load to two following edges, so a command in each of those cycles, and a legal one right after the window, can all be reached. With four banks, every bank-select value is exercised. That covers the undefined mode-select values 2 and 3 and activates to several banks, which lead into active versus idle power-down. A long pseudo-random phase with occasional clock-enable toggles then reaches mixes of open rows, self refresh and illegal sequences that the directed part does not cover.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_NOP     = 4'd0,
    CMD_MRS     = 4'd1,
    CMD_EMRS    = 4'd2,
    CMD_ACT     = 4'd3,
    CMD_RD      = 4'd4,
    CMD_WR      = 4'd5,
    CMD_BST     = 4'd6,
    CMD_PRE     = 4'd7,
    CMD_PREA    = 4'd8,
    CMD_REF     = 4'd9,
    CMD_SRE     = 4'd10,
    CMD_SRX     = 4'd11,
    CMD_PDE_PRE = 4'd12,
    CMD_PDE_ACT = 4'd13,
    CMD_PDX     = 4'd14
  } cmd_e;

  localparam int CMD_N = 15;
endpackage

// File: rtl/sdram_cmd_classify.sv
module sdram_cmd_classify
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              cke_prev_i,
  input  logic              cke_i,
  input  logic              a10_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic              sr_active_i,
  input  logic              any_open_i,
  output cmd_e              cmd_o
);
  logic [2:0] code;
  logic       idle_code;

  assign code      = {ras_ni, cas_ni, we_ni};
  assign idle_code = cs_ni || (code == 3'b111);

  always_comb begin
    cmd_o = CMD_NOP;
    unique case ({cke_prev_i, cke_i})
      2'b11: begin
        if (!cs_ni) begin
          case (code)
            3'b000: begin
              if (ba_i == BANK_W'(0))      cmd_o = CMD_MRS;
              else if (ba_i == BANK_W'(1)) cmd_o = CMD_EMRS;
            end
            3'b001:  cmd_o = CMD_REF;
            3'b010:  cmd_o = a10_i ? CMD_PREA : CMD_PRE;
            3'b011:  cmd_o = CMD_ACT;
            3'b100:  cmd_o = CMD_WR;
            3'b101:  cmd_o = CMD_RD;
            3'b110:  cmd_o = CMD_BST;
            default: cmd_o = CMD_NOP;
          endcase
        end
      end
      2'b10: begin
        if (!cs_ni && code == 3'b001) cmd_o = CMD_SRE;
        else if (idle_code)           cmd_o = any_open_i ? CMD_PDE_ACT : CMD_PDE_PRE;
      end
      2'b01: begin
        if (idle_code) cmd_o = sr_active_i ? CMD_SRX : CMD_PDX;
      end
      default: cmd_o = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_cmd_legal.sv
module sdram_cmd_legal
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  cmd_e                 cmd_i,
  input  logic [BANK_W-1:0]    ba_i,
  input  logic [NUM_BANKS-1:0] open_i,
  input  logic                 mrd_busy_i,
  output logic                 illegal_o
);
  logic any_open;
  logic bank_open;
  logic needs_idle;

  assign any_open   = |open_i;
  assign bank_open  = open_i[ba_i];
  assign needs_idle = (cmd_i == CMD_MRS) || (cmd_i == CMD_EMRS) ||
                      (cmd_i == CMD_REF) || (cmd_i == CMD_SRE);

  always_comb begin
    illegal_o = 1'b0;
    if (mrd_busy_i && cmd_i != CMD_NOP)                  illegal_o = 1'b1;
    if (needs_idle && any_open)                          illegal_o = 1'b1;
    if (cmd_i == CMD_ACT && bank_open)                   illegal_o = 1'b1;
    if ((cmd_i == CMD_RD || cmd_i == CMD_WR) && !bank_open) illegal_o = 1'b1;
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_W     = 2,
  parameter int MRD_CYCLES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  cmd_e                 cmd_i,
  input  logic [BANK_W-1:0]    ba_i,
  input  logic                 a10_i,
  input  logic                 illegal_i,
  input  logic                 cke_rise_i,
  output logic [NUM_BANKS-1:0] open_o,
  output logic                 mrd_busy_o,
  output logic                 sr_active_o
);
  localparam int MRD_W = $clog2(MRD_CYCLES + 1);
  localparam logic [MRD_W-1:0] MRD_LOAD = MRD_W'(MRD_CYCLES - 1);

  logic [MRD_W-1:0] mrd_q;
  logic             legal;
  logic             col_ap;

  assign legal  = !illegal_i;
  assign col_ap = a10_i && (cmd_i == CMD_RD || cmd_i == CMD_WR);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (ba_i == BANK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[b] <= 1'b0;
      end else if (legal) begin
        if (cmd_i == CMD_ACT && hit)                              open_o[b] <= 1'b1;
        else if ((cmd_i == CMD_PRE && hit) || cmd_i == CMD_PREA)  open_o[b] <= 1'b0;
        else if (col_ap && hit)                                   open_o[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mrd_q <= '0;
    end else if (legal && (cmd_i == CMD_MRS || cmd_i == CMD_EMRS)) begin
      mrd_q <= MRD_LOAD;
    end else if (mrd_q != '0) begin
      mrd_q <= mrd_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sr_active_o <= 1'b0;
    else if (cmd_i == CMD_SRE)   sr_active_o <= 1'b1;
    else if (cke_rise_i)         sr_active_o <= 1'b0;
  end

  assign mrd_busy_o = (mrd_q != '0);
endmodule

// File: rtl/sdram_cmd_dec.sv
module sdram_cmd_dec
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int MRD_CYCLES = 2,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic                 cke_i,
  input  logic                 a10_i,
  input  logic [BANK_W-1:0]    ba_i,
  output logic [CMD_N-1:0]     cmd_o,
  output logic [BANK_W-1:0]    bank_o,
  output logic                 auto_pre_o,
  output logic                 illegal_o,
  output logic [NUM_BANKS-1:0] open_rows_o
);
  logic             cke_q;
  logic             sr_active;
  logic             mrd_busy;
  logic             illegal_d;
  cmd_e             cmd_d;
  logic [CMD_N-1:0] onehot_d;
  logic             bank_cmd;

  sdram_cmd_classify #(.BANK_W(BANK_W)) u_classify (
    .cs_ni       (cs_ni),
    .ras_ni      (ras_ni),
    .cas_ni      (cas_ni),
    .we_ni       (we_ni),
    .cke_prev_i  (cke_q),
    .cke_i       (cke_i),
    .a10_i       (a10_i),
    .ba_i        (ba_i),
    .sr_active_i (sr_active),
    .any_open_i  (|open_rows_o),
    .cmd_o       (cmd_d)
  );

  sdram_cmd_legal #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_legal (
    .cmd_i      (cmd_d),
    .ba_i       (ba_i),
    .open_i     (open_rows_o),
    .mrd_busy_i (mrd_busy),
    .illegal_o  (illegal_d)
  );

  sdram_bank_track #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .MRD_CYCLES(MRD_CYCLES)
  ) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd_d),
    .ba_i        (ba_i),
    .a10_i       (a10_i),
    .illegal_i   (illegal_d),
    .cke_rise_i  (!cke_q && cke_i),
    .open_o      (open_rows_o),
    .mrd_busy_o  (mrd_busy),
    .sr_active_o (sr_active)
  );

  always_comb begin
    onehot_d        = '0;
    onehot_d[cmd_d] = 1'b1;
  end

  assign bank_cmd = (cmd_d == CMD_ACT) || (cmd_d == CMD_RD) ||
                    (cmd_d == CMD_WR)  || (cmd_d == CMD_PRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q      <= 1'b1;
      cmd_o      <= CMD_N'(1);
      bank_o     <= '0;
      auto_pre_o <= 1'b0;
      illegal_o  <= 1'b0;
    end else begin
      cke_q      <= cke_i;
      cmd_o      <= onehot_d;
      bank_o     <= bank_cmd ? ba_i : '0;
      auto_pre_o <= a10_i && (cmd_d == CMD_RD || cmd_d == CMD_WR);
      illegal_o  <= illegal_d;
    end
  end
endmodule

// File: rtl/sdram_cmd_dec_chk.sv
module sdram_cmd_dec_chk
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cs_ni,
  input logic                 cke_i,
  input logic [CMD_N-1:0]     cmd_o,
  input logic [BANK_W-1:0]    bank_o,
  input logic                 auto_pre_o,
  input logic                 illegal_o,
  input logic [NUM_BANKS-1:0] open_rows_o
);
  p_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cmd_o) == 1);

  p_desel_nop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && cke_i && $past(cke_i)) |=> cmd_o[CMD_NOP]);

  p_autopre_col_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_pre_o |-> (cmd_o[CMD_RD] || cmd_o[CMD_WR]));

  p_act_opens_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_ACT] && !illegal_o) |-> open_rows_o[bank_o]);

  p_prea_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_PREA] && !illegal_o) |-> (open_rows_o == '0));

  p_illegal_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $stable(open_rows_o));

  p_idle_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o[CMD_MRS] || cmd_o[CMD_EMRS] || cmd_o[CMD_REF] || cmd_o[CMD_SRE])
     && ($past(open_rows_o) != '0)) |-> illegal_o);
endmodule

bind sdram_cmd_dec sdram_cmd_dec_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .cke_i       (cke_i),
  .cmd_o       (cmd_o),
  .bank_o      (bank_o),
  .auto_pre_o  (auto_pre_o),
  .illegal_o   (illegal_o),
  .open_rows_o (open_rows_o)
);

// File: tb/sim_sdram_cmd_dec.sv
module sim_sdram_cmd_dec;
  import sdram_cmd_pkg::*;

  localparam int PERIOD = 10;
  localparam int NB     = 4;
  localparam int BW     = 2;
  localparam int MRD    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic cke = 1'b1, a10 = 1'b0;
  logic [BW-1:0] ba = '0;
  logic [CMD_N-1:0] cmd;
  logic [BW-1:0] bank;
  logic auto_pre, illegal;
  logic [NB-1:0] open_rows;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference state
  int m_open = 0, m_mrd = 0;
  bit m_sr = 0, m_prev = 1;
  int e_cmd, e_bank;
  bit e_ap, e_ill;

  always #(PERIOD/2) clk = ~clk;

  sdram_cmd_dec #(.NUM_BANKS(NB), .MRD_CYCLES(MRD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .cke_i(cke), .a10_i(a10), .ba_i(ba), .cmd_o(cmd),
    .bank_o(bank), .auto_pre_o(auto_pre), .illegal_o(illegal), .open_rows_o(open_rows)
  );

  function automatic string req_of(int c);
    case (c)
      CMD_MRS, CMD_EMRS: return "R5";
      CMD_PRE, CMD_PREA: return "R4";
      CMD_SRE, CMD_PDE_PRE, CMD_PDE_ACT: return "R6";
      CMD_SRX, CMD_PDX: return "R7";
      CMD_NOP: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic model();
    int code = {ras_n, cas_n, we_n};
    bit any = (m_open != 0);
    bit idle = cs_n || code == 7;
    bit bopen = m_open[ba];
    e_cmd = CMD_NOP;
    if (m_prev && cke) begin
      if (!cs_n) begin
        case (code)
          0: e_cmd = (ba == 0) ? CMD_MRS : (ba == 1) ? CMD_EMRS : CMD_NOP;
          1: e_cmd = CMD_REF;
          2: e_cmd = a10 ? CMD_PREA : CMD_PRE;
          3: e_cmd = CMD_ACT;
          4: e_cmd = CMD_WR;
          5: e_cmd = CMD_RD;
          6: e_cmd = CMD_BST;
          default: e_cmd = CMD_NOP;
        endcase
      end
    end else if (m_prev && !cke) begin
      if (!cs_n && code == 1) e_cmd = CMD_SRE;
      else if (idle) e_cmd = any ? CMD_PDE_ACT : CMD_PDE_PRE;
    end else if (!m_prev && cke) begin
      if (idle) e_cmd = m_sr ? CMD_SRX : CMD_PDX;
    end
    e_ill = (e_cmd != CMD_NOP && m_mrd > 0) ||
            ((e_cmd == CMD_MRS || e_cmd == CMD_EMRS || e_cmd == CMD_REF || e_cmd == CMD_SRE) && any) ||
            (e_cmd == CMD_ACT && bopen) ||
            ((e_cmd == CMD_RD || e_cmd == CMD_WR) && !bopen);
    e_bank = (e_cmd == CMD_ACT || e_cmd == CMD_RD || e_cmd == CMD_WR || e_cmd == CMD_PRE) ? int'(ba) : 0;
    e_ap = a10 && (e_cmd == CMD_RD || e_cmd == CMD_WR);
    if (!e_ill) begin
      if (e_cmd == CMD_ACT) m_open[ba] = 1'b1;
      if (e_cmd == CMD_PRE) m_open[ba] = 1'b0;
      if (e_cmd == CMD_PREA) m_open = 0;
      if (e_ap) m_open[ba] = 1'b0;
    end
    if (!e_ill && (e_cmd == CMD_MRS || e_cmd == CMD_EMRS)) m_mrd = MRD - 1;
    else if (m_mrd > 0) m_mrd--;
    if (e_cmd == CMD_SRE) m_sr = 1;
    else if (!m_prev && cke) m_sr = 0;
    m_prev = cke;
  endtask

  task automatic compare();
    logic [CMD_N-1:0] ec = '0;
    ec[e_cmd] = 1'b1;
    n_vec++;
    if (cmd !== ec) begin
      n_bad++;
      $display("FAIL %s R1 cmd: got %b exp %b", req_of(e_cmd), cmd, ec);
    end else if (bank !== BW'(e_bank)) begin
      n_bad++;
      $display("FAIL R3 bank: got %0d exp %0d", bank, e_bank);
    end else if (auto_pre !== e_ap) begin
      n_bad++;
      $display("FAIL R4 auto_pre: got %b exp %b", auto_pre, e_ap);
    end else if (illegal !== e_ill) begin
      n_bad++;
      $display("FAIL %s illegal: got %b exp %b", (m_mrd > 0 || e_cmd == CMD_NOP) ? "R10" : "R9", illegal, e_ill);
    end else if (open_rows !== NB'(m_open)) begin
      n_bad++;
      $display("FAIL R8 open_rows: got %b exp %b", open_rows, NB'(m_open));
    end
  endtask

  task automatic apply(input bit c, input bit [2:0] code, input bit k, input bit a, input int b);
    @(negedge clk);
    cs_n = c; {ras_n, cas_n, we_n} = code; cke = k; a10 = a; ba = BW'(b);
    @(posedge clk);
    model();
    #(PERIOD/4);
    compare();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    // R1: reset state
    n_vec++;
    if (cmd !== CMD_N'(1) || bank !== '0 || auto_pre || illegal || open_rows !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: got cmd %b open %b exp %b 0", cmd, open_rows, CMD_N'(1));
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R5 mode loads and R10 guard window
    apply(0, 3'b000, 1, 0, 0);
    apply(1, 3'b111, 1, 0, 0);
    apply(1, 3'b111, 1, 0, 0);
    apply(0, 3'b000, 1, 0, 1);
    apply(0, 3'b011, 1, 0, 2);   // R10: inside window
    apply(0, 3'b011, 1, 0, 2);   // R10: still inside
    apply(0, 3'b011, 1, 0, 2);   // R3 activate legal
    apply(0, 3'b000, 1, 0, 2);   // R5 undefined ba -> nop
    apply(0, 3'b000, 1, 0, 0);   // R9 mode load with open row
    apply(0, 3'b101, 1, 1, 2);   // R4 read auto precharge
    apply(0, 3'b100, 1, 0, 1);   // R9 write closed bank
    apply(0, 3'b011, 1, 0, 0);
    apply(0, 3'b011, 1, 0, 0);   // R9 act to open bank
    apply(0, 3'b110, 1, 0, 3);   // R3 burst stop
    apply(1, 3'b011, 1, 0, 3);   // R2 deselect masks
    apply(1, 3'b111, 0, 0, 0);   // R6 active power-down
    apply(1, 3'b111, 0, 0, 0);   // R7 held low
    apply(0, 3'b111, 1, 0, 0);   // R7 power-down exit
    apply(0, 3'b010, 1, 1, 3);   // R4 precharge all
    apply(0, 3'b001, 1, 0, 0);   // R3 auto refresh
    apply(1, 3'b111, 0, 0, 0);   // R6 idle power-down
    apply(0, 3'b011, 1, 0, 0);   // R7 rise with other code -> nop
    apply(0, 3'b001, 0, 0, 0);   // R6 self-refresh entry
    apply(1, 3'b111, 0, 0, 0);
    apply(1, 3'b111, 1, 0, 0);   // R7 self-refresh exit
    apply(0, 3'b011, 1, 0, 1);
    apply(0, 3'b010, 1, 0, 1);   // R8 single precharge
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit k = (r < 8) ? ~cke : cke;
      apply($urandom_range(0, 9) < 2, 3'($urandom_range(0, 7)), k,
            1'($urandom_range(0, 1)), $urandom_range(0, NB - 1));
    end
    finish_run();
  end
endmodule